// File: doc/BRIEF.md
# Vectored interrupt controller

This block collects up to 32 interrupt request lines into one interrupt signal for a processor. Every source has a status bit. A level-kind source copies its line into that bit. An edge-kind source sets the bit on a rising transition and keeps it set until software clears it. Each source is made level-kind or edge-kind by a parameter mask fixed at elaboration. The status word is ANDed with an enable word to give the pending word. A lowest-index encoder turns the pending word into a vector number. Two master bits act separately: one opens the capture of source events and the other allows the output.

Software uses a word-addressed write port and a read port that answers in the same cycle. It acknowledges sources by writing ones to an acknowledge offset. It changes the enable word without a read-modify-write through a set offset and a clear offset. It reads the vector number to choose a handler. Source lines may be asynchronous to the bus clock. They pass through a synchroniser of configurable depth before any event is detected.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears status, enable and master words to zero. After reset the vector offset (6) reads 32'hFFFF_FFFF and the output is low.
- R2: Offset 1 reads status AND enable after every write and every capture. A write to offset 1 or offset 6 leaves no trace in any readback.
- R3: Offset 6 reads the index of the lowest set pending bit, zero-extended. It reads all ones when nothing is pending.
- R4: Writing offset 3 clears every status bit whose written bit is 1 and leaves the others unchanged. Offset 3 reads zero.
- R5: Writing offset 2 loads the enable word. Writing offset 4 ORs the value into it. Writing offset 5 clears the enable bits written as 1. Offsets 4 and 5 read zero.
- R6: Writing offset 0 loads the status word and writing offset 7 loads the full master word. Both read back exactly what was stored.
- R7: The output is high exactly when master bit 0 (output enable) and master bit 1 (capture enable) are both 1 and pending is nonzero.
- R8: While master bit 1 is 0, source transitions change no status bit, and they are not replayed once capture is enabled again.
- R9: For an edge-kind source, a 0-to-1 transition of the synchronised line sets its status bit two clock edges after the line is first sampled high. A falling line or a line held high sets nothing further.
- R10: For a level-kind source, each change of the synchronised line copies the new level into its status bit with the same two-edge delay.
- R11: If a capture event and a status write or acknowledge hit the same bit in the same cycle, the capture event decides the bit.
- R12: Offsets 8 and above read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and capture clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NSRC | Interrupt request lines, may be asynchronous |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | ADDR_W | Word offset for the read and the write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, valid in the same cycle |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that bus_wr, bus_addr and bus_wdata carry defined values whenever reset is low. They also assume that an acknowledge or status write never lands on the same bit as a level event without that event winning. A line that toggles faster than the synchroniser can pass is taken to have no defined effect. The stimulus therefore changes the lines and the bus only on the falling clock edge. In directed phases it holds every line level for at least three cycles. It sweeps the delay between a rising edge and its acknowledge so that one case lands exactly on the capture cycle. A random phase then mixes writes to all offsets, including unmapped ones, with single-bit line flips.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   typedef enum logic [2:0] {
      RG_STAT  = 3'd0,
      RG_PEND  = 3'd1,
      RG_ENA   = 3'd2,
      RG_ACK   = 3'd3,
      RG_SETEN = 3'd4,
      RG_CLREN = 3'd5,
      RG_VEC   = 3'd6,
      RG_MAST  = 3'd7
   } irqc_reg_e;

   localparam int unsigned IRQC_NUM_REGS = 8;
   localparam int unsigned IRQC_SEL_W    = 3;
   localparam int unsigned MB_OUT_EN     = 0;
   localparam int unsigned MB_CAP_EN     = 1;

   typedef struct packed {
      logic ld_stat;
      logic ack;
      logic ld_en;
      logic set_en;
      logic clr_en;
      logic ld_mast;
   } irqc_wr_t;

endpackage

// File: rtl/irqc_bus_decode.sv
module irqc_bus_decode
   import irqc_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
)(
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output irqc_wr_t          wr_o,
   output logic              hit_o,
   output irqc_reg_e         sel_o
);

   logic in_map;

   generate
      if (ADDR_W == IRQC_SEL_W) begin : g_exact
         assign in_map = 1'b1;
      end else begin : g_wide
         assign in_map = (bus_addr[ADDR_W-1:IRQC_SEL_W] == '0);
      end
   endgenerate

   assign sel_o = irqc_reg_e'(bus_addr[IRQC_SEL_W-1:0]);
   assign hit_o = in_map;

   always_comb begin
      wr_o         = '0;
      if (bus_wr && in_map) begin
         wr_o.ld_stat = (sel_o == RG_STAT);
         wr_o.ack     = (sel_o == RG_ACK);
         wr_o.ld_en   = (sel_o == RG_ENA);
         wr_o.set_en  = (sel_o == RG_SETEN);
         wr_o.clr_en  = (sel_o == RG_CLREN);
         wr_o.ld_mast = (sel_o == RG_MAST);
      end
   end

endmodule

// File: rtl/irqc_src_capture.sv
module irqc_src_capture #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          IS_EDGE     = 1'b0
)(
   input  logic clk,
   input  logic rst,
   input  logic src_in,
   input  logic cap_en,
   input  logic ld_en,
   input  logic ld_val,
   input  logic ack,
   output logic stat_o
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   line_s;
   logic                   change;
   logic                   evt;
   logic                   evt_val;
   logic                   stat_q;

   assign line_s = sync_q[SYNC_STAGES-1];
   assign change = line_s ^ prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], src_in};
         prev_q <= line_s;
      end
   end

   generate
      if (IS_EDGE) begin : g_edge
         assign evt     = cap_en & change & line_s;
         assign evt_val = 1'b1;
      end else begin : g_level
         assign evt     = cap_en & change;
         assign evt_val = line_s;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)        stat_q <= 1'b0;
      else if (evt)   stat_q <= evt_val;
      else if (ld_en) stat_q <= ld_val;
      else if (ack)   stat_q <= 1'b0;
   end

   assign stat_o = stat_q;

   p_gate_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (!cap_en && !ld_en && !ack) |=> $stable(stat_q));

   p_ack_clear_r4: assert property (@(posedge clk) disable iff (rst)
      (ack && !ld_en && !(cap_en && change)) |=> !stat_q);

   generate
      if (IS_EDGE) begin : g_edge_chk
         p_edge_set_r9: assert property (@(posedge clk) disable iff (rst)
            (cap_en && change && line_s) |=> stat_q);
         p_edge_beats_ack_r11: assert property (@(posedge clk) disable iff (rst)
            (cap_en && change && line_s && ack) |=> stat_q);
         p_edge_fall_r9: assert property (@(posedge clk) disable iff (rst)
            (!line_s && !ld_en && !ack) |=> (stat_q || !$past(stat_q)));
      end else begin : g_level_chk
         p_level_follow_r10: assert property (@(posedge clk) disable iff (rst)
            (cap_en && change) |=> (stat_q == $past(line_s)));
      end
   endgenerate

endmodule

// File: rtl/irqc_lowest_enc.sv
module irqc_lowest_enc #(
   parameter int unsigned W     = 32,
   parameter int unsigned IDX_W = 5
)(
   input  logic [W-1:0]     req,
   output logic [IDX_W-1:0] idx_o,
   output logic             any_o
);

   always_comb begin
      idx_o = '0;
      any_o = 1'b0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx_o = IDX_W'(i);
            any_o = 1'b1;
         end
      end
   end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned     NSRC        = 32,
   parameter int unsigned     DATA_W      = 32,
   parameter int unsigned     ADDR_W      = 4,
   parameter int unsigned     SYNC_STAGES = 2,
   parameter logic [NSRC-1:0] EDGE_KIND   = '0
)(
   input  logic              clk,
   input  logic              rst,
   input  logic [NSRC-1:0]   irq_src,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);

   localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

   generate
      if (NSRC < 2 || NSRC > DATA_W) begin : g_bad_nsrc
         $error("vec_irq_ctrl: NSRC must lie in 2..DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("vec_irq_ctrl: DATA_W must hold both master bits");
      end
      if (ADDR_W < IRQC_SEL_W) begin : g_bad_addr
         $error("vec_irq_ctrl: ADDR_W too small for the register map");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("vec_irq_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   irqc_wr_t          wr;
   logic              hit;
   irqc_reg_e         sel;
   logic [NSRC-1:0]   wsrc;
   logic [NSRC-1:0]   stat;
   logic [NSRC-1:0]   ena_q;
   logic [NSRC-1:0]   pend;
   logic [NSRC-1:0]   lower_mask;
   logic [DATA_W-1:0] mast_q;
   logic [DATA_W-1:0] stat_w;
   logic [DATA_W-1:0] ena_w;
   logic [DATA_W-1:0] pend_w;
   logic [DATA_W-1:0] vec_w;
   logic [IDX_W-1:0]  vec_idx;
   logic              vec_any;

   assign wsrc = bus_wdata[NSRC-1:0];

   irqc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .wr_o     (wr),
      .hit_o    (hit),
      .sel_o    (sel)
   );

   always_ff @(posedge clk) begin
      if (rst)             ena_q <= '0;
      else if (wr.ld_en)   ena_q <= wsrc;
      else if (wr.set_en)  ena_q <= ena_q | wsrc;
      else if (wr.clr_en)  ena_q <= ena_q & ~wsrc;
   end

   always_ff @(posedge clk) begin
      if (rst)             mast_q <= '0;
      else if (wr.ld_mast) mast_q <= bus_wdata;
   end

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         irqc_src_capture #(
            .SYNC_STAGES (SYNC_STAGES),
            .IS_EDGE     (EDGE_KIND[i])
         ) u_cap (
            .clk    (clk),
            .rst    (rst),
            .src_in (irq_src[i]),
            .cap_en (mast_q[MB_CAP_EN]),
            .ld_en  (wr.ld_stat),
            .ld_val (wsrc[i]),
            .ack    (wr.ack & wsrc[i]),
            .stat_o (stat[i])
         );
      end
   endgenerate

   assign pend = stat & ena_q;

   irqc_lowest_enc #(.W(NSRC), .IDX_W(IDX_W)) u_enc (
      .req   (pend),
      .idx_o (vec_idx),
      .any_o (vec_any)
   );

   always_comb begin
      stat_w             = '0;
      ena_w              = '0;
      pend_w             = '0;
      stat_w[NSRC-1:0]   = stat;
      ena_w[NSRC-1:0]    = ena_q;
      pend_w[NSRC-1:0]   = pend;
      vec_w              = vec_any ? DATA_W'(vec_idx) : '1;
   end

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         unique case (sel)
            RG_STAT: bus_rdata = stat_w;
            RG_PEND: bus_rdata = pend_w;
            RG_ENA:  bus_rdata = ena_w;
            RG_VEC:  bus_rdata = vec_w;
            RG_MAST: bus_rdata = mast_q;
            default: bus_rdata = '0;
         endcase
      end
   end

   assign irq_o = mast_q[MB_OUT_EN] & mast_q[MB_CAP_EN] & vec_any;

   assign lower_mask = (NSRC'(1) << vec_idx) - NSRC'(1);

   p_vec_hit_r3: assert property (@(posedge clk) disable iff (rst)
      (pend != '0) |-> pend[vec_idx]);

   p_vec_lowest_r3: assert property (@(posedge clk) disable iff (rst)
      (pend != '0) |-> ((pend & lower_mask) == '0));

   p_vec_none_r3: assert property (@(posedge clk) disable iff (rst)
      (pend == '0) |-> (vec_w == '1));

   p_set_en_r5: assert property (@(posedge clk) disable iff (rst)
      wr.set_en |=> ((ena_q & $past(wsrc)) == $past(wsrc)));

   p_clr_en_r5: assert property (@(posedge clk) disable iff (rst)
      wr.clr_en |=> ((ena_q & $past(wsrc)) == '0));

   p_out_off_r7: assert property (@(posedge clk) disable iff (rst)
      (wr.ld_mast && !bus_wdata[MB_OUT_EN]) |=> !irq_o);

   p_oob_write_r12: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && !hit) |=> ($stable(ena_q) && $stable(mast_q)));

endmodule

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;

   localparam logic [31:0] EDGES = 32'hFFFF_0000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] irq_in = '0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   bit [31:0] m_stat, m_ena, m_mast;
   bit [31:0] hist[$] = '{32'h0, 32'h0, 32'h0};

   always #5 clk = ~clk;

   vec_irq_ctrl #(
      .NSRC(32), .DATA_W(32), .ADDR_W(4), .SYNC_STAGES(2), .EDGE_KIND(EDGES)
   ) u0 (
      .clk(clk), .rst(rst), .irq_src(irq_in), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o)
   );

   function automatic bit [31:0] m_vec();
      for (int i = 0; i < 32; i++)
         if (m_stat[i] && m_ena[i]) return 32'(i);
      return 32'hFFFF_FFFF;
   endfunction

   function automatic bit [31:0] m_read(int a);
      case (a)
         0: return m_stat;
         1: return m_stat & m_ena;
         2: return m_ena;
         6: return m_vec();
         7: return m_mast;
         default: return 32'h0;
      endcase
   endfunction

   function automatic bit m_irq();
      return m_mast[0] && m_mast[1] && ((m_stat & m_ena) != 0);
   endfunction

   // behavioural reference: line sample history, then write, then capture
   always @(posedge clk) begin
      bit [31:0] s, p, nstat, nena, nmast;
      if (rst) begin
         m_stat = 0; m_ena = 0; m_mast = 0;
         hist = '{32'h0, 32'h0, 32'h0};
      end else begin
         s = hist[1]; p = hist[2];
         nstat = m_stat; nena = m_ena; nmast = m_mast;
         if (bus_wr) begin
            case (int'(bus_addr))
               0: nstat = bus_wdata;
               2: nena = bus_wdata;
               3: nstat = m_stat & ~bus_wdata;
               4: nena = m_ena | bus_wdata;
               5: nena = m_ena & ~bus_wdata;
               7: nmast = bus_wdata;
               default: ;
            endcase
         end
         if (m_mast[1]) begin
            for (int i = 0; i < 32; i++) begin
               if (s[i] != p[i]) begin
                  if (EDGES[i]) begin
                     if (s[i]) nstat[i] = 1'b1;
                  end else nstat[i] = s[i];
               end
            end
         end
         m_stat = nstat; m_ena = nena; m_mast = nmast;
         hist.push_front(irq_in);
         void'(hist.pop_back());
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (!done) begin
         chk({cur_req, " model rdata"}, bus_rdata, m_read(int'(bus_addr)));
         chk({cur_req, " model irq"}, {31'b0, irq_o}, {31'b0, m_irq()});
      end
   end

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(string tag, int a, logic [31:0] exp);
      @(negedge clk);
      bus_addr = 4'(a);
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic irq_chk(string tag, logic exp);
      #1;
      chk(tag, {31'b0, irq_o}, {31'b0, exp});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;

      cur_req = "R1";
      for (int a = 0; a < 8; a++)
         rd("R1 reset readback", a, (a == 6) ? 32'hFFFF_FFFF : 32'h0);
      irq_chk("R1 reset irq", 1'b0);

      cur_req = "R6";
      wr(0, 32'h0000_8421);
      rd("R6 status store", 0, 32'h0000_8421);
      wr(7, 32'hA5A5_0000);
      rd("R6 master store", 7, 32'hA5A5_0000);
      wr(7, 32'h0);

      cur_req = "R5";
      wr(2, 32'h0000_00F0);
      wr(4, 32'h0000_0F00);
      rd("R5 set-enable", 2, 32'h0000_0FF0);
      wr(5, 32'h0000_0030);
      rd("R5 clear-enable", 2, 32'h0000_0FC0);
      rd("R5 set offset reads zero", 4, 32'h0);

      cur_req = "R2";
      rd("R2 pending", 1, 32'h0000_0400);
      wr(1, 32'hFFFF_FFFF);
      rd("R2 pending write ignored", 1, 32'h0000_0400);
      wr(6, 32'h0);
      rd("R2 vector write ignored", 6, 32'd10);

      cur_req = "R3";
      wr(2, 32'hFFFF_FFFF);
      rd("R3 vector lowest", 6, 32'd0);
      cur_req = "R4";
      wr(3, 32'h0000_0001);
      rd("R4 ack one bit", 0, 32'h0000_8420);
      rd("R3 vector after ack", 6, 32'd5);
      rd("R4 ack offset reads zero", 3, 32'h0);
      wr(3, 32'hFFFF_FFFF);
      rd("R4 ack all", 0, 32'h0);
      rd("R3 vector empty", 6, 32'hFFFF_FFFF);

      cur_req = "R7";
      wr(0, 32'h8000_0000);
      wr(7, 32'h1);
      irq_chk("R7 capture bit off", 1'b0);
      wr(7, 32'h3);
      irq_chk("R7 both bits on", 1'b1);
      wr(7, 32'h2);
      irq_chk("R7 output bit off", 1'b0);
      wr(7, 32'h3);
      wr(2, 32'h0);
      irq_chk("R7 nothing enabled", 1'b0);
      wr(2, 32'hFFFF_FFFF);
      wr(3, 32'hFFFF_FFFF);

      cur_req = "R10";
      @(negedge clk); irq_in[3] = 1'b1;
      idle(3);
      rd("R10 level rise", 0, 32'h0000_0008);
      rd("R10 level vector", 6, 32'd3);
      irq_chk("R10 irq on level", 1'b1);
      @(negedge clk); irq_in[3] = 1'b0;
      idle(3);
      rd("R10 level fall", 0, 32'h0);
      irq_chk("R10 irq off", 1'b0);

      cur_req = "R9";
      @(negedge clk); irq_in[20] = 1'b1;
      idle(3);
      rd("R9 edge set", 0, 32'h0010_0000);
      @(negedge clk); irq_in[20] = 1'b0;
      idle(3);
      rd("R9 edge held after fall", 0, 32'h0010_0000);
      rd("R9 vector", 6, 32'd20);
      wr(3, 32'h0010_0000);
      rd("R9 edge acked", 0, 32'h0);
      @(negedge clk); irq_in[21] = 1'b1;
      idle(3);
      wr(3, 32'h0020_0000);
      idle(2);
      rd("R9 held line no reset", 0, 32'h0);
      @(negedge clk); irq_in[21] = 1'b0;
      idle(3);

      cur_req = "R8";
      wr(7, 32'h1);
      @(negedge clk); irq_in[4] = 1'b1; irq_in[22] = 1'b1;
      idle(4);
      rd("R8 gated capture", 0, 32'h0);
      irq_chk("R8 irq low", 1'b0);
      wr(7, 32'h3);
      idle(3);
      rd("R8 no replay", 0, 32'h0);
      @(negedge clk); irq_in[4] = 1'b0; irq_in[22] = 1'b0;
      idle(3);

      cur_req = "R11";
      for (int d = 0; d < 4; d++) begin
         @(negedge clk); irq_in[24] = 1'b1;
         idle(d);
         wr(3, 32'h0100_0000);
         idle(1);
         rd("R11 set vs ack", 0, (d <= 1) ? 32'h0100_0000 : 32'h0);
         @(negedge clk); irq_in[24] = 1'b0;
         idle(3);
         wr(3, 32'hFFFF_FFFF);
      end

      cur_req = "R12";
      rd("R12 offset 8", 8, 32'h0);
      rd("R12 offset 15", 15, 32'h0);
      wr(9, 32'h0);
      wr(12, 32'h0);
      rd("R12 enable untouched", 2, 32'hFFFF_FFFF);
      rd("R12 master untouched", 7, 32'h3);

      cur_req = "R2 random";
      for (int n = 0; n < 600; n++) begin
         @(negedge clk);
         bus_wr = ($urandom_range(0, 2) == 0);
         bus_addr = 4'($urandom_range(0, 9));
         bus_wdata = (bus_addr == 4'd7) ? 32'($urandom_range(0, 3)) : $urandom;
         if ($urandom_range(0, 1) == 1)
            irq_in[$urandom_range(0, 31)] ^= 1'b1;
      end
      @(negedge clk); bus_wr = 1'b0;
      idle(4);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule